// File: doc/BRIEF.md
# Serial Audio Stereo Receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, left/right word clock, data) and turns every half-frame into a 24-bit two's-complement sample. Each sample goes to a left or a right output register. A one-cycle strobe marks each complete left/right pair. Everything runs on the master clock: the bit clock and word clock are sampled as ordinary inputs, and their edges are found with registers.

The bit clock can come from the link itself, or from an internal divider that toggles every `DIV_HALF` master-clock cycles. In the internal case the divided clock is driven out so that the source can shift data on it. The number of bit-clock pulses in a word-clock phase sets the word length. A short word is padded with zeros at the bottom. A long word is cut off once the word limit is reached. The limit is 24 bits, or `NARROW_BITS` when the internal clock runs in its narrow ratio.

Top module: `stereo_serial_rx`

## Requirements
- R1: A word received while the word clock is low goes to `left_out`. A word received while it is high goes to `right_out`.
- R2: Bits arrive most significant first. The first bit-clock rising edge after any word-clock edge carries no data. The second rising edge captures bit 23, and each later rising edge captures the next lower bit.
- R3: If a phase delivers fewer bits than the word limit, every bit below the last one received reads as zero.
- R4: Bits beyond the word limit in a phase are discarded and do not change the stored word.
- R5: The word limit is 24 bits when `ext_bclk`=1, and 24 bits when `ext_bclk`=0 with `wide_int`=1. It is `NARROW_BITS` (16) when `ext_bclk`=0 with `wide_int`=0.
- R6: A word is written to its channel register at the word-clock edge that ends its phase. Both channel registers hold their value at all other times.
- R7: `pair_valid` is high for exactly one master-clock cycle, together with the new `right_out`. It follows a right-channel commit only if a left-channel commit has happened since the previous strobe.
- R8: After reset, the phase in progress before the first word-clock edge is never committed.
- R9: With `ext_bclk`=0, `bclk_gen` toggles every `DIV_HALF` (4) master-clock cycles. With `ext_bclk`=1 it stays low, and `bclk_in` is the bit clock.
- R10: While and right after reset, `left_out`, `right_out`, `pair_valid` and `bclk_gen` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_bclk | input | 1 | 1: bit clock taken from `bclk_in`; 0: internal divider |
| wide_int | input | 1 | Internal mode only: 1 selects 24-bit words, 0 selects `NARROW_BITS` |
| bclk_in | input | 1 | External bit clock |
| wclk_in | input | 1 | Word clock, low = left, high = right |
| sdata_in | input | 1 | Serial data, MSB first |
| bclk_gen | output | 1 | Internally divided bit clock |
| left_out | output | 24 | Last committed left sample |
| right_out | output | 24 | Last committed right sample |
| pair_valid | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
The bench drives phases of 1 to 32 data bits in both bit-clock modes. A receiver that used the first rising edge would shift the whole word up by one bit. One that left stale low bits would fail the padding cases, and one that kept shifting past the limit would corrupt words longer than 24 bits, or longer than 16 in narrow mode. A short preamble after each reset sends a partial first phase and a right-only phase. A receiver that committed before the first word-clock edge, or strobed a pair without a left word, is caught by the strobe count and the register contents. The divider's period is measured directly, and `bclk_gen` is checked to stay idle in external mode.

// File: rtl/stereo_rx_pkg.sv
package stereo_rx_pkg;
  localparam int WORD_W = 24;
  localparam int IDX_W  = $clog2(WORD_W + 1);

  typedef logic [WORD_W-1:0] sample_t;
  typedef logic [IDX_W-1:0]  bitidx_t;

  // Word limit for the current bit-clock source and ratio.
  function automatic bitidx_t pick_cap(logic ext, logic wide, bitidx_t narrow);
    return (ext || wide) ? bitidx_t'(WORD_W) : narrow;
  endfunction

  // Write a received bit at its MSB-first position.
  function automatic sample_t place_bit(sample_t w, bitidx_t idx, logic b);
    sample_t r;
    bitidx_t pos;
    r   = w;
    pos = bitidx_t'(WORD_W - 1) - idx;
    r[pos] = b;
    return r;
  endfunction
endpackage

// File: rtl/rx_sync_edge.sv
module rx_sync_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  for (genvar g = 0; g < W; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl[g]  <= 1'b0;
        prev[g] <= 1'b0;
      end else begin
        lvl[g]  <= raw[g];
        prev[g] <= lvl[g];
      end
    end
  end
endmodule

// File: rtl/rx_bclk_divider.sv
module rx_bclk_divider #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic bclk
);
  localparam int CNT_W = $clog2(DIV_HALF + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_word_assembler.sv
module rx_word_assembler
  import stereo_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    word_edge,
  input  logic    bit_rise,
  input  logic    sbit,
  input  bitidx_t cap,
  output sample_t word,
  output bitidx_t taken,
  output logic    bit_take
);
  logic lead_seen;

  // Capture happens only past the lead edge and below the limit.
  assign bit_take = bit_rise && !word_edge && lead_seen && (taken < cap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word      <= '0;
      taken     <= '0;
      lead_seen <= 1'b0;
    end else if (word_edge) begin
      word      <= '0;
      taken     <= '0;
      lead_seen <= bit_rise;
    end else if (bit_rise) begin
      if (!lead_seen) begin
        lead_seen <= 1'b1;
      end else if (bit_take) begin
        word  <= place_bit(word, taken, sbit);
        taken <= taken + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_channel_router.sv
module rx_channel_router
  import stereo_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    word_edge,
  input  logic    ending_level,
  input  sample_t word,
  output sample_t left_q,
  output sample_t right_q,
  output logic    pair_q,
  output logic    commit_left,
  output logic    commit_right
);
  logic armed;
  logic left_seen;

  assign commit_left  = word_edge && armed && !ending_level;
  assign commit_right = word_edge && armed &&  ending_level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      left_seen <= 1'b0;
      left_q    <= '0;
      right_q   <= '0;
      pair_q    <= 1'b0;
    end else begin
      pair_q <= commit_right && left_seen;
      if (word_edge) armed <= 1'b1;
      if (commit_left) begin
        left_q    <= word;
        left_seen <= 1'b1;
      end
      if (commit_right) begin
        right_q   <= word;
        left_seen <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
  import stereo_rx_pkg::*;
#(
  parameter int NARROW_BITS = 16,
  parameter int DIV_HALF    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_bclk,
  input  logic              wide_int,
  input  logic              bclk_in,
  input  logic              wclk_in,
  input  logic              sdata_in,
  output logic              bclk_gen,
  output logic [WORD_W-1:0] left_out,
  output logic [WORD_W-1:0] right_out,
  output logic              pair_valid
);
  localparam int SYNC_W = 2;
  localparam int LANE_B = 0;
  localparam int LANE_W = 1;

  // Named internal events
  logic              bclk_src;
  logic [SYNC_W-1:0] lvl;
  logic [SYNC_W-1:0] prev;
  logic              sdata_q;
  logic              bit_rise;
  logic              word_edge;
  logic              ending_level;
  bitidx_t           bit_cap;
  bitidx_t           bits_taken;
  logic              bit_take;
  sample_t           cur_word;
  logic              commit_left;
  logic              commit_right;

  rx_bclk_divider #(.DIV_HALF(DIV_HALF)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (!ext_bclk),
    .bclk  (bclk_gen)
  );

  assign bclk_src = ext_bclk ? bclk_in : bclk_gen;

  rx_sync_edge #(.W(SYNC_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   ({wclk_in, bclk_src}),
    .lvl   (lvl),
    .prev  (prev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sdata_q <= 1'b0;
    else        sdata_q <= sdata_in;
  end

  assign bit_rise     = lvl[LANE_B] && !prev[LANE_B];
  assign word_edge    = lvl[LANE_W] != prev[LANE_W];
  assign ending_level = prev[LANE_W];
  assign bit_cap      = pick_cap(ext_bclk, wide_int, bitidx_t'(NARROW_BITS));

  rx_word_assembler u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_edge (word_edge),
    .bit_rise  (bit_rise),
    .sbit      (sdata_q),
    .cap       (bit_cap),
    .word      (cur_word),
    .taken     (bits_taken),
    .bit_take  (bit_take)
  );

  rx_channel_router u_route (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_edge    (word_edge),
    .ending_level (ending_level),
    .word         (cur_word),
    .left_q       (left_out),
    .right_q      (right_out),
    .pair_q       (pair_valid),
    .commit_left  (commit_left),
    .commit_right (commit_right)
  );
endmodule

// File: rtl/stereo_rx_checker.sv
module stereo_rx_checker
  import stereo_rx_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    ext_bclk,
  input logic    bclk_gen,
  input logic    pair_valid,
  input sample_t left_out,
  input sample_t right_out,
  input logic    commit_left,
  input logic    commit_right,
  input logic    word_edge,
  input bitidx_t bits_taken,
  input bitidx_t bit_cap
);
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  assert_strobe_after_right_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> $past(commit_right));

  assert_left_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit_left) |-> $stable(left_out));

  assert_right_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit_right) |-> $stable(right_out));

  assert_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bits_taken <= bit_cap);

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_edge |=> (bits_taken == '0));

  assert_gen_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_bclk && $past(ext_bclk)) |-> !bclk_gen);
endmodule

bind stereo_serial_rx stereo_rx_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ext_bclk     (ext_bclk),
  .bclk_gen     (bclk_gen),
  .pair_valid   (pair_valid),
  .left_out     (left_out),
  .right_out    (right_out),
  .commit_left  (commit_left),
  .commit_right (commit_right),
  .word_edge    (word_edge),
  .bits_taken   (bits_taken),
  .bit_cap      (bit_cap)
);

// File: tb/stereo_serial_rx_test.sv
`timescale 1ns/1ps
module stereo_serial_rx_test;
  localparam int HALF_EXT = 3;
  localparam int DIVH     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_bclk = 1'b1;
  logic wide_int = 1'b0;
  logic bclk_in = 1'b0;
  logic wclk_in = 1'b0;
  logic sdata_in = 1'b0;
  logic bclk_gen;
  logic [23:0] left_out;
  logic [23:0] right_out;
  logic pair_valid;

  int tests = 0;
  int fails = 0;
  int strobes = 0;
  bit finished = 1'b0;
  logic [23:0] exp_l[$];
  logic [23:0] exp_r[$];

  always #2 clk = ~clk;

  stereo_serial_rx #(.NARROW_BITS(16), .DIV_HALF(DIVH)) uut (
    .clk(clk), .rst_n(rst_n), .ext_bclk(ext_bclk), .wide_int(wide_int),
    .bclk_in(bclk_in), .wclk_in(wclk_in), .sdata_in(sdata_in),
    .bclk_gen(bclk_gen), .left_out(left_out), .right_out(right_out),
    .pair_valid(pair_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected word: the first min(n, limit) sent bits, MSB-aligned, zeros below.
  function automatic logic [23:0] expect_word(logic [31:0] pat, int n, int lim);
    logic [23:0] e = '0;
    int keep = (n < lim) ? n : lim;
    for (int k = 0; k < keep; k++) e[23-k] = pat[31-k];
    return e;
  endfunction

  function automatic int cur_limit();
    return (ext_bclk || wide_int) ? 24 : 16;
  endfunction

  // Strobe monitor: R1, R7
  always @(negedge clk) begin
    if (rst_n && pair_valid) begin
      strobes++;
      if (exp_l.size() == 0) begin
        check("R7 unexpected strobe", 32'd1, 32'd0);
      end else begin
        check("R1 left word", {8'h0, left_out}, {8'h0, exp_l.pop_front()});
        check("R1 right word", {8'h0, right_out}, {8'h0, exp_r.pop_front()});
      end
    end
  end

  task automatic wait_gen_fall();
    logic p;
    forever begin
      p = bclk_gen;
      @(negedge clk);
      if (p && !bclk_gen) break;
    end
  endtask

  // One word-clock phase carrying n data bits after the lead pulse.
  task automatic phase(input logic lvl, input int n, input logic [31:0] pat);
    if (ext_bclk) begin
      @(negedge clk);
      wclk_in = lvl;
      for (int p = 0; p <= n; p++) begin
        sdata_in = (p == 0) ? 1'($urandom) : pat[31-(p-1)];
        repeat (HALF_EXT) @(negedge clk);
        bclk_in = 1'b1;
        repeat (HALF_EXT) @(negedge clk);
        bclk_in = 1'b0;
      end
    end else begin
      wait_gen_fall();
      wclk_in = lvl;
      sdata_in = 1'($urandom);
      for (int p = 1; p <= n; p++) begin
        wait_gen_fall();
        sdata_in = pat[31-(p-1)];
      end
    end
  endtask

  task automatic send_pair(input int nl, input logic [31:0] pl, input int nr, input logic [31:0] pr);
    exp_l.push_back(expect_word(pl, nl, cur_limit()));
    exp_r.push_back(expect_word(pr, nr, cur_limit()));
    phase(1'b0, nl, pl);
    phase(1'b1, nr, pr);
  endtask

  task automatic start_segment(input logic ext, input logic wide);
    rst_n = 1'b0;
    ext_bclk = ext;
    wide_int = wide;
    bclk_in = 1'b0;
    wclk_in = 1'b0;
    sdata_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 reset left", {8'h0, left_out}, 32'h0);
    check("R10 reset right", {8'h0, right_out}, 32'h0);
    check("R10 reset strobe", {31'h0, pair_valid}, 32'h0);
    check("R10 reset divider", {31'h0, bclk_gen}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Partial first phase, then a right-only phase, then a left phase in progress.
  task automatic preamble_and_check();
    int s0;
    logic [31:0] pb;
    pb = $urandom;
    s0 = strobes;
    phase(1'b0, 8, 32'hFFFF_FFFF);
    phase(1'b1, 8, pb);
    exp_l.push_back(expect_word(32'h8000_0001, 24, cur_limit()));
    phase(1'b0, 24, 32'h8000_0001);
    check("R8 first phase dropped, left untouched", {8'h0, left_out}, 32'h0);
    check("R6 right committed at edge", {8'h0, right_out}, {8'h0, expect_word(pb, 8, cur_limit())});
    check("R7 no strobe without left", strobes, s0);
    exp_r.push_back(expect_word(32'h7FFF_FFFF, 20, cur_limit()));
    phase(1'b1, 20, 32'h7FFF_FFFF);
  endtask

  task automatic finish_segment(input int want);
    phase(1'b0, 2, 32'h0);
    repeat (8) @(negedge clk);
    check("R7 strobe count", strobes, want);
    check("R7 queue drained", exp_l.size(), 0);
  endtask

  initial begin
    int base;
    int t0;
    int per;
    void'($urandom(32'h00C0FFEE));

    // External bit clock segment
    start_segment(1'b1, 1'b0);
    base = strobes;
    preamble_and_check();
    send_pair(24, 32'hA5C3_F00F, 24, 32'h1234_5678);   // R2 full word
    send_pair(16, 32'hFFFF_FFFF, 12, 32'h8001_FFFF);   // R3 padding
    send_pair(30, 32'h0F0F_F0F3, 32, 32'hFFFF_FFFF);   // R4 truncation
    send_pair(1, 32'h8000_0000, 25, 32'h0000_0000);    // R3 single bit
    for (int i = 0; i < 10; i++)
      send_pair($urandom_range(1, 32), $urandom, $urandom_range(1, 32), $urandom);
    check("R9 divider idle in external mode", {31'h0, bclk_gen}, 32'h0);
    finish_segment(base + 15);

    // Internal narrow segment
    start_segment(1'b0, 1'b0);
    base = strobes;
    @(posedge bclk_gen);
    t0 = $time;
    @(posedge bclk_gen);
    per = ($time - t0) / 4;
    check("R9 divider period", per, 2 * DIVH);
    preamble_and_check();
    send_pair(16, 32'hDEAD_BEEF, 20, 32'hFFFF_FFFF);   // R5 narrow limit
    send_pair(15, 32'h1357_9BDF, 31, 32'h2468_ACE0);
    for (int i = 0; i < 4; i++)
      send_pair($urandom_range(1, 32), $urandom, $urandom_range(1, 32), $urandom);
    finish_segment(base + 7);

    // Internal wide segment
    start_segment(1'b0, 1'b1);
    base = strobes;
    preamble_and_check();
    send_pair(24, 32'hCAFE_F00D, 28, 32'hFFFF_FFFF);   // R5 wide limit
    for (int i = 0; i < 4; i++)
      send_pair($urandom_range(1, 32), $urandom, $urandom_range(1, 32), $urandom);
    finish_segment(base + 6);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule